// File: doc/BRIEF.md
# Converter Control Word and Channel Sequencer

This block holds the 16-bit control word of a multi-channel sampling converter and drives the order of conversions. A serial slave front end delivers the word as two byte writes. The first byte fills the upper half of the word, and the word is applied only once the second byte arrives. The upper byte is a per-channel enable mask. The lower byte carries these mode bits:

- autocycle
- self-clearing soft reset
- alert clear
- alert polarity
- reference select
- background temperature enable

The sequencer walks the enabled channels from the lowest index upward. A start request makes it pass over the mask once. In autocycle it repeats the pass without further requests. The converter answers each start pulse with a done handshake. A background timer raises temperature-conversion ticks at a fixed interval. A tick that falls due while a channel is converting is held and issued before the next channel starts. A new control word reaches the sequencer only at a conversion boundary, and the sequencer then starts again from the lowest channel of the new mask.

Top module: `adcseq_top`

## Requirements
- R1: The control word changes only when the second of two byte writes is taken. The first byte becomes bits 15..8 and the second byte becomes bits 7..0. A lone first byte changes no output.
- R2: After the reset input, the control word is zero. In that state `extRefSel`, `alertClr`, `emptyErr`, `convStart` and `tempTick` are 0, and `alertPin` equals `alertRaw`.
- R3: A start request with a non-empty mask (bits 15..8, bit n = channel n) gives one single-cycle `convStart` per enabled channel, in ascending channel order. `chanIdx` holds that channel's index while `convStart` is high. A conversion starts only after `convDone` for the previous one. After the highest enabled channel no further start follows.
- R4: With bit 0 (autocycle) set, the enabled channels are converted over and over in ascending order without any start request.
- R5: A start request with an all-zero mask produces no `convStart` and sets `emptyErr`, which then stays set until a reset.
- R6: Taking a second byte with bit 1 set returns every register to its reset value, including the control word itself. A conversion in flight is abandoned. After this soft reset the next two bytes again load bits 15..8 then 7..0.
- R7: Bit 3 sets the alert polarity: `alertPin` = `alertRaw` when bit 3 is 0, and the inverse of `alertRaw` when bit 3 is 1.
- R8: `alertClr` is high exactly while bit 2 of the control word is 1.
- R9: `extRefSel` follows bit 4. Bit 6 (and bit 5) have no effect on any output.
- R10: With bit 7 set and no conversion running, `tempTick` pulses once every TEMP_PERIOD cycles. With bit 7 clear there are no ticks.
- R11: A temperature tick that falls due during a channel conversion is held. It is issued after `convDone`, one cycle before the next `convStart`, and never in the same cycle as `convStart`.
- R12: A word loaded while a conversion is running leaves `chanIdx` and the running conversion unchanged. At the next `convDone` the sequencer starts from the lowest channel of the new mask, or goes idle if that mask is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Byte-write strobe from the serial front end |
| wrData | input | 8 | Byte written with the strobe |
| startReq | input | 1 | Request one pass over the enabled channels |
| convDone | input | 1 | Converter signals the end of the current conversion |
| alertRaw | input | 1 | Active-high alert condition from the limit logic |
| chanIdx | output | 3 | Channel being converted or next to be converted |
| convStart | output | 1 | Single-cycle start of a channel conversion |
| tempTick | output | 1 | Single-cycle start of a temperature conversion |
| extRefSel | output | 1 | External reference selected |
| alertPin | output | 1 | Alert level after polarity selection |
| alertClr | output | 1 | Clear level for the alert status |
| emptyErr | output | 1 | Sticky: a start was requested with no channel enabled |

## Verification
A wrong current index or a wrong walk over the mask shows up on `chanIdx` at the very next `convStart`. That is no later than one converter round trip after the fault. A byte-phase fault misaligns every later word, and the mode levels show it in the cycle after the second byte. A stale active mask or a lost dirty marker shows at the first conversion boundary after a write. A held temperature tick that is dropped or issued early is caught in the cycle after `convDone`, where the tick must come before the next start.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CH_COUNT = 8;
  localparam int CH_W     = $clog2(CH_COUNT);
  localparam int BYTE_W   = 8;

  // positions in the low byte of the control word
  localparam int BIT_AUTO   = 0;
  localparam int BIT_SRST   = 1;
  localparam int BIT_ACLR   = 2;
  localparam int BIT_APOL   = 3;
  localparam int BIT_EXTREF = 4;
  localparam int BIT_TEMP   = 7;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMask;
    logic pickLowest;
    logic pickHigher;
    logic tempAck;
    logic setErr;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic cmdMaskAny;
    logic cmdAuto;
    logic actAuto;
    logic hasHigher;
    logic cmdDirty;
    logic tempPend;
    logic softRst;
  } seqStat_t;
endpackage

// File: rtl/adcseq_dp.sv
module adcseq_dp
  import adcseq_pkg::*;
#(
  parameter int TEMP_PERIOD = 1000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStb,
  input  logic [BYTE_W-1:0]   wrData,
  input  seqCmd_t             ctl,
  output seqStat_t            stat,
  output logic [CH_W-1:0]     chanIdx,
  output logic                extRefSel,
  output logic                alertPolLow,
  output logic                alertClr,
  output logic                emptyErr
);
  localparam int TW = (TEMP_PERIOD > 2) ? $clog2(TEMP_PERIOD) : 1;

  logic [BYTE_W-1:0]   hiByte;
  logic                bytePhase;
  logic [CH_COUNT-1:0] cmdMask;
  logic                cmdAuto, cmdAclr, cmdApol, cmdExt, cmdTemp;
  logic                cmdDirty;
  logic [CH_COUNT-1:0] actMask;
  logic                actAuto;
  logic [CH_W-1:0]     curIdx;
  logic [TW-1:0]       tempCnt;
  logic                tempPend;
  logic                errFlag;

  logic                softRst, commit, tempWrap;
  logic [CH_COUNT-1:0] srcMask, aboveMask;
  logic [CH_W-1:0]     lowIdx, highIdx;

  function automatic logic [CH_W-1:0] lowestIdx(input logic [CH_COUNT-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (m[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  assign softRst  = wrStb && bytePhase && wrData[BIT_SRST];
  assign commit   = wrStb && bytePhase && !wrData[BIT_SRST];
  assign tempWrap = cmdTemp && (tempCnt == TW'(TEMP_PERIOD - 1));

  assign srcMask = ctl.loadMask ? cmdMask : actMask;
  assign lowIdx  = lowestIdx(srcMask);

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_above
    assign aboveMask[g] = actMask[g] && (CH_W'(g) > curIdx);
  end
  assign highIdx = lowestIdx(aboveMask);

  // byte assembly and control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByte    <= '0;
      bytePhase <= 1'b0;
      cmdMask   <= '0;
      {cmdAuto, cmdAclr, cmdApol, cmdExt, cmdTemp} <= '0;
      cmdDirty  <= 1'b0;
    end else if (softRst) begin
      hiByte    <= '0;
      bytePhase <= 1'b0;
      cmdMask   <= '0;
      {cmdAuto, cmdAclr, cmdApol, cmdExt, cmdTemp} <= '0;
      cmdDirty  <= 1'b0;
    end else begin
      if (ctl.loadMask) cmdDirty <= 1'b0;
      if (wrStb && !bytePhase) begin
        hiByte    <= wrData;
        bytePhase <= 1'b1;
      end
      if (commit) begin
        bytePhase <= 1'b0;
        cmdMask   <= hiByte;
        cmdAuto   <= wrData[BIT_AUTO];
        cmdAclr   <= wrData[BIT_ACLR];
        cmdApol   <= wrData[BIT_APOL];
        cmdExt    <= wrData[BIT_EXTREF];
        cmdTemp   <= wrData[BIT_TEMP];
        cmdDirty  <= 1'b1;
      end
    end
  end

  // active sequence state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMask <= '0;
      actAuto <= 1'b0;
      curIdx  <= '0;
      errFlag <= 1'b0;
    end else if (softRst) begin
      actMask <= '0;
      actAuto <= 1'b0;
      curIdx  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (ctl.loadMask) begin
        actMask <= cmdMask;
        actAuto <= cmdAuto;
      end
      if (ctl.pickLowest)      curIdx <= lowIdx;
      else if (ctl.pickHigher) curIdx <= highIdx;
      if (ctl.setErr) errFlag <= 1'b1;
    end
  end

  // background temperature interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempCnt  <= '0;
      tempPend <= 1'b0;
    end else if (softRst || !cmdTemp) begin
      tempCnt  <= '0;
      tempPend <= 1'b0;
    end else begin
      tempCnt  <= tempWrap ? '0 : tempCnt + 1'b1;
      tempPend <= (tempPend && !ctl.tempAck) || tempWrap;
    end
  end

  always_comb begin
    stat            = '0;
    stat.cmdMaskAny = |cmdMask;
    stat.cmdAuto    = cmdAuto;
    stat.actAuto    = actAuto;
    stat.hasHigher  = |aboveMask;
    stat.cmdDirty   = cmdDirty;
    stat.tempPend   = tempPend;
    stat.softRst    = softRst;
  end

  assign chanIdx     = curIdx;
  assign extRefSel   = cmdExt;
  assign alertPolLow = cmdApol;
  assign alertClr    = cmdAclr;
  assign emptyErr    = errFlag;
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     convDone,
  input  seqStat_t stat,
  output seqCmd_t  ctl,
  output logic     convStart,
  output logic     tempTick
);
  seqState_t state, nxt;

  always_comb begin
    ctl         = '0;
    nxt         = state;
    convStart   = 1'b0;
    tempTick    = stat.tempPend && (state != SEQ_WAIT);
    ctl.tempAck = tempTick;
    unique case (state)
      SEQ_IDLE: begin
        ctl.loadMask = 1'b1;
        if (stat.cmdMaskAny && (startReq || stat.cmdAuto)) begin
          ctl.pickLowest = 1'b1;
          nxt = SEQ_ISSUE;
        end else if (startReq && !stat.cmdMaskAny) begin
          ctl.setErr = 1'b1;
        end
      end
      SEQ_ISSUE: begin
        if (!stat.tempPend) begin
          convStart = 1'b1;
          nxt = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (convDone) begin
          if (stat.cmdDirty) begin
            ctl.loadMask = 1'b1;
            if (stat.cmdMaskAny) begin
              ctl.pickLowest = 1'b1;
              nxt = SEQ_ISSUE;
            end else begin
              nxt = SEQ_IDLE;
            end
          end else if (stat.hasHigher) begin
            ctl.pickHigher = 1'b1;
            nxt = SEQ_ISSUE;
          end else if (stat.actAuto) begin
            ctl.pickLowest = 1'b1;
            nxt = SEQ_ISSUE;
          end else begin
            nxt = SEQ_IDLE;
          end
        end
      end
      default: nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             state <= SEQ_IDLE;
    else if (stat.softRst) state <= SEQ_IDLE;
    else                   state <= nxt;
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int TEMP_PERIOD = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              startReq,
  input  logic              convDone,
  input  logic              alertRaw,
  output logic [CH_W-1:0]   chanIdx,
  output logic              convStart,
  output logic              tempTick,
  output logic              extRefSel,
  output logic              alertPin,
  output logic              alertClr,
  output logic              emptyErr
);
  seqCmd_t  ctl;
  seqStat_t stat;
  logic     alertPolLow;

  adcseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .convDone(convDone),
    .stat(stat), .ctl(ctl), .convStart(convStart), .tempTick(tempTick)
  );

  adcseq_dp #(.TEMP_PERIOD(TEMP_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .ctl(ctl),
    .stat(stat), .chanIdx(chanIdx), .extRefSel(extRefSel),
    .alertPolLow(alertPolLow), .alertClr(alertClr), .emptyErr(emptyErr)
  );

  assign alertPin = alertRaw ^ alertPolLow;
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic startReq,
  input logic alertRaw,
  input logic alertPin,
  input logic convStart,
  input logic tempTick,
  input logic extRefSel,
  input logic emptyErr
);
  // R1
  word_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> $stable(extRefSel));

  // R3
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R5
  empty_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyErr) |-> $past(startReq));

  // R5
  empty_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyErr && !wrStb) |=> emptyErr);

  // R7
  alert_pin_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> (!$stable(alertRaw) || $stable(alertPin)));

  // R11
  tick_start_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(convStart && tempTick));
endmodule

bind adcseq_top adcseq_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .startReq(startReq),
  .alertRaw(alertRaw), .alertPin(alertPin), .convStart(convStart),
  .tempTick(tempTick), .extRefSel(extRefSel), .emptyErr(emptyErr)
);

// File: tb/adcseq_top_test.sv
`timescale 1ns/1ps
module adcseq_top_test;
  localparam int TP = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic       startReq = 1'b0;
  logic       convDone = 1'b0;
  logic       alertRaw = 1'b0;
  logic [2:0] chanIdx;
  logic       convStart, tempTick, extRefSel, alertPin, alertClr, emptyErr;

  int total = 0;
  int bad = 0;
  int extraStarts = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adcseq_top #(.TEMP_PERIOD(TP)) uut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .startReq(startReq), .convDone(convDone), .alertRaw(alertRaw),
    .chanIdx(chanIdx), .convStart(convStart), .tempTick(tempTick),
    .extRefSel(extRefSel), .alertPin(alertPin), .alertClr(alertClr),
    .emptyErr(emptyErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCmd(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); wrStb = 1'b1; wrData = hi;
    @(negedge clk); wrData = lo;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitConv(output int got, output bit ok);
    ok = 1'b0; got = -1;
    for (int i = 0; i < 20; i++) begin
      if (convStart) begin
        ok = 1'b1; got = int'(chanIdx);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic finishConv(input int lat);
    repeat (lat) begin
      @(negedge clk);
      if (convStart) extraStarts++;
    end
    convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
  endtask

  task automatic countStarts(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (convStart) c++;
    end
  endtask

  task automatic countTicks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (tempTick) c++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    int got, c, last, cyc, n;
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(extRefSel == 0 && alertClr == 0 && emptyErr == 0, "R2 mode levels", {extRefSel, alertClr, emptyErr}, 0);
    chk(convStart == 0 && tempTick == 0, "R2 pulses", {convStart, tempTick}, 0);
    chk(alertPin == alertRaw, "R2 alert pin", alertPin, alertRaw);

    // R1 byte assembly and order
    @(negedge clk); wrStb = 1'b1; wrData = 8'hFF;
    @(negedge clk); wrStb = 1'b0;
    chk(extRefSel == 0 && alertClr == 0, "R1 lone first byte", {extRefSel, alertClr}, 0);
    @(negedge clk); wrStb = 1'b1; wrData = 8'h10;
    @(negedge clk); wrStb = 1'b0;
    chk(extRefSel == 1, "R1 second byte applies", extRefSel, 1);
    writeCmd(8'h10, 8'h00);
    chk(extRefSel == 0, "R1 first byte is upper", extRefSel, 0);
    writeCmd(8'h00, 8'h10);
    chk(extRefSel == 1, "R1 second byte is lower (R9 ext ref)", extRefSel, 1);
    writeCmd(8'h00, 8'h00);

    // R3 / R5 sweep over every mask
    for (int m = 0; m < 256; m++) begin
      writeCmd(8'(m), 8'h00);
      pulseStart();
      if (m == 0) begin
        countStarts(10, c);
        chk(c == 0, "R5 no start on empty mask", c, 0);
        chk(emptyErr == 1, "R5 empty error set", emptyErr, 1);
        countStarts(5, c);
        chk(emptyErr == 1, "R5 empty error sticky", emptyErr, 1);
        writeCmd(8'h00, 8'h02);
        chk(emptyErr == 0, "R6 soft reset clears error", emptyErr, 0);
      end else begin
        for (int ch = 0; ch < 8; ch++) begin
          if (m[ch]) begin
            waitConv(got, ok);
            chk(ok && got == ch, "R3 ascending channel", got, ch);
            finishConv(3);
          end
        end
        countStarts(10, c);
        chk(c == 0, "R3 pass ends after top channel", c, 0);
      end
    end
    chk(extraStarts == 0, "R3 start only after done", extraStarts, 0);

    // R4 autocycle on channels 2 and 5
    writeCmd(8'h24, 8'h01);
    for (int k = 0; k < 5; k++) begin
      waitConv(got, ok);
      chk(ok && got == ((k % 2) ? 5 : 2), "R4 autocycle order", got, (k % 2) ? 5 : 2);
      if (k < 4) finishConv(2);
    end
    writeCmd(8'h00, 8'h00);
    finishConv(2);
    countStarts(10, c);
    chk(c == 0, "R12 empty new mask stops at boundary", c, 0);

    // R12 word change mid conversion
    writeCmd(8'h0F, 8'h00);
    pulseStart();
    waitConv(got, ok);
    chk(ok && got == 0, "R12 first channel", got, 0);
    writeCmd(8'h60, 8'h00);
    chk(chanIdx == 0 && convStart == 0, "R12 running conversion untouched", chanIdx, 0);
    finishConv(2);
    waitConv(got, ok);
    chk(ok && got == 5, "R12 restart at lowest of new mask", got, 5);
    finishConv(2);
    waitConv(got, ok);
    chk(ok && got == 6, "R12 continue new mask", got, 6);
    finishConv(2);
    countStarts(10, c);
    chk(c == 0, "R12 new pass ends", c, 0);

    // R6 soft reset
    writeCmd(8'h00, 8'h1C);
    chk(extRefSel == 1 && alertClr == 1 && alertPin == 1, "R6 modes before reset", {extRefSel, alertClr, alertPin}, 7);
    pulseStart();
    @(negedge clk);
    chk(emptyErr == 1, "R5 error before reset", emptyErr, 1);
    writeCmd(8'h00, 8'h1E);
    chk(extRefSel == 0 && alertClr == 0 && alertPin == 0 && emptyErr == 0, "R6 all defaults",
        {extRefSel, alertClr, alertPin, emptyErr}, 0);
    writeCmd(8'h00, 8'h10);
    chk(extRefSel == 1, "R6 byte order after reset", extRefSel, 1);
    writeCmd(8'h03, 8'h01);
    waitConv(got, ok);
    chk(ok && got == 0, "R6 autocycle before reset", got, 0);
    writeCmd(8'h00, 8'h02);
    finishConv(2);
    countStarts(10, c);
    chk(c == 0, "R6 conversion abandoned", c, 0);

    // R7 polarity
    for (int p = 0; p < 2; p++) begin
      writeCmd(8'h00, p ? 8'h08 : 8'h00);
      for (int r = 0; r < 2; r++) begin
        @(negedge clk); alertRaw = r[0];
        #1;
        chk(alertPin == (r[0] ^ p[0]), "R7 alert polarity", alertPin, r ^ p);
      end
    end
    alertRaw = 1'b0;

    // R8 alert clear level
    writeCmd(8'h00, 8'h04);
    chk(alertClr == 1, "R8 clear set", alertClr, 1);
    writeCmd(8'h00, 8'h00);
    chk(alertClr == 0, "R8 clear released", alertClr, 0);

    // R9 bit 6 has no effect
    writeCmd(8'h00, 8'h60);
    countTicks(60, c);
    chk(c == 0 && extRefSel == 0 && alertClr == 0 && alertPin == alertRaw && emptyErr == 0,
        "R9 bits 6 and 5 inert", c, 0);

    // R10 temperature interval
    writeCmd(8'h00, 8'h80);
    last = -1; n = 0;
    for (cyc = 0; cyc < 130; cyc++) begin
      @(negedge clk);
      if (tempTick) begin
        if (last >= 0) chk(cyc - last == TP, "R10 tick spacing", cyc - last, TP);
        last = cyc; n++;
      end
    end
    chk(n >= 6, "R10 tick count", n, 6);
    writeCmd(8'h00, 8'h00);
    countTicks(60, c);
    chk(c == 0, "R10 no ticks when disabled", c, 0);

    // R11 tick held during conversion
    writeCmd(8'h03, 8'h80);
    pulseStart();
    waitConv(got, ok);
    chk(ok && got == 0, "R11 first channel", got, 0);
    c = 0;
    repeat (45) begin
      @(negedge clk);
      if (tempTick) c++;
    end
    chk(c == 0, "R11 no tick during conversion", c, 0);
    convDone = 1'b1;
    @(negedge clk); convDone = 1'b0;
    chk(tempTick == 1 && convStart == 0, "R11 held tick first", {tempTick, convStart}, 2);
    @(negedge clk);
    chk(convStart == 1 && chanIdx == 1, "R11 next channel after tick", {convStart, chanIdx}, 9);
    writeCmd(8'h00, 8'h00);
    finishConv(2);

    summary();
  end
endmodule